// File: doc/BRIEF.md
# Interrupt Flag, Mask and Wake-up Controller

This block collects three interrupt sources for a small 8-bit core: a one-cycle overflow pulse from a timer, a difference between an 8-bit input port and the value latched when software last read that port, and a falling edge on an external interrupt pin. Each source sets a sticky flag. A mask register enables each source on its own, and a global enable is driven by instruction strobes from the core: enable, disable and return-from-interrupt. Acknowledging an interrupt also drops the global enable.

The block raises a request toward the core when the global enable is set and any masked flag is pending. It also tracks a sleep state entered on a sleep strobe. While asleep, a pending and enabled port-change flag produces a one-cycle wake pulse. Beside that pulse the block reports whether execution must branch to the interrupt vector (global enable set) or resume at the instruction after sleep (global enable clear). Software may only clear flags. A flag read returns each flag already ANDed with its mask bit.

Top module: `irq_wake_ctrl`

## Requirements
- R1: While rst_n is low and after it rises, all flags, all mask bits, the global enable and the sleep state are 0, so flag_rd_data, mask_rd_data, irq_req and wake all read 0. The external pin synchronizer resets to the idle-high level.
- R2: Flag bit 0 is set by tmr_ovf, bit 1 by a port-change mismatch, and bit 2 by a qualified external falling edge. Each flag is set on the clock edge that samples its event. Writing a 1 to a flag bit that is 0 leaves it at 0.
- R3: On a flag write (flag_wr_en), each flag bit 2..0 whose wr_data bit is 0 is cleared and each whose wr_data bit is 1 is kept. A source event in the same cycle wins, and that flag ends up set.
- R4: flag_rd_data bits 2..0 equal flag AND mask, and bits 7..3 read 0. A mask write (mask_wr_en) loads wr_data bits 2..0. mask_rd_data returns the mask in bits 2..0, with 0 above. Mask bit n set to 1 enables source n.
- R5: op_eni or op_reti sets the global enable on the next edge, and op_disi clears it. If a disable and a set arrive in the same cycle, the disable wins.
- R6: irq_req is 1 exactly when the global enable is set and (flags AND mask) is nonzero. It follows the registered state with no extra delay.
- R7: irq_ack clears the global enable on the next edge and wins over a same-cycle op_eni or op_reti. Only a later op_eni or op_reti sets it again.
- R8: ext_pin passes two synchronizer flops before falling-edge detection. A pin driven low after an edge sets flag bit 2 on the third rising edge after that. Edges seen while ext_sel is 0 set nothing.
- R9: port_rd latches port_in as the reference, and the reference resets to 0x00. In every cycle that port_in differs from the reference, flag bit 1 is set again, so a clearing write does not hold until the port is read again.
- R10: op_sleep enters sleep. While asleep, flag bit 1 with mask bit 1 raises wake for exactly one cycle and leaves sleep. wake_vec equals the global enable during that cycle (1 means branch to the vector, 0 means resume). Timer and external flags never raise wake, and wake stays 0 while awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 8 | Write data for flag and mask registers |
| flag_wr_en | input | 1 | Flag register write strobe (clear-only) |
| mask_wr_en | input | 1 | Mask register write strobe |
| flag_rd_data | output | 8 | Flags ANDed with mask, upper bits 0 |
| mask_rd_data | output | 8 | Mask register, upper bits 0 |
| tmr_ovf | input | 1 | Timer overflow pulse |
| port_in | input | 8 | Live input port value |
| port_rd | input | 1 | Port read strobe, latches the change reference |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ext_sel | input | 1 | 1 selects interrupt function for the pin |
| op_eni | input | 1 | Enable-interrupts instruction strobe |
| op_disi | input | 1 | Disable-interrupts instruction strobe |
| op_reti | input | 1 | Return-from-interrupt instruction strobe |
| op_sleep | input | 1 | Sleep instruction strobe |
| irq_ack | input | 1 | Core accepts the interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | One-cycle wake pulse to the sleep logic |
| wake_vec | output | 1 | 1: branch to vector after wake, 0: resume |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a clearing write to the flag register and a source event for the same bit. The bench issues a timer pulse, and later a persisting port mismatch, in the very cycle of a write of zeros, and expects the flag to read back set. The second pair is a set of the global enable (op_eni) together with op_disi or irq_ack. The bench raises both strobes together and expects irq_req to stay low afterwards with a masked flag pending. Around these collisions, a sweep over all mask values and all clear patterns compares every read against flags AND mask computed in the bench.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
    parameter int NUM_SRC = 3;
    localparam int SRC_TMR  = 0;
    localparam int SRC_PORT = 1;
    localparam int SRC_EXT  = 2;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t flag;
        src_vec_t mask;
        logic     gie;
        logic     asleep;
    } core_state_t;
endpackage

// File: rtl/iwc_port_change.sv
module iwc_port_change #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic              port_rd,
    output logic              change
);
    logic [PORT_W-1:0] ref_d, ref_q;

    always_comb begin
        ref_d  = ref_q;
        if (port_rd) ref_d = port_in;
        change = (port_in != ref_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= '0;
        else        ref_q <= ref_d;
    end

    // R9: a read captures the port value as the new reference
    a_r9_ref_latch: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |=> (ref_q == $past(port_in)));
endmodule

// File: rtl/iwc_ext_edge.sv
module iwc_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sel,
    output logic fall
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_state_t;

    edge_state_t s_d, s_q;
    logic [SYNC_STAGES-1:0] stage_in;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            assign stage_in[g] = pin;
        end else begin : g_next
            assign stage_in[g] = s_q.sync[g-1];
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.sync = stage_in;
        s_d.prev = s_q.sync[SYNC_STAGES-1];
        fall     = sel & s_q.prev & ~s_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    // R8: one falling edge yields one detection cycle
    a_r8_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/iwc_core.sv
module iwc_core
    import irq_wake_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t ev,
    input  logic     flag_wr,
    input  logic     mask_wr,
    input  src_vec_t wr_bits,
    input  logic     op_eni,
    input  logic     op_disi,
    input  logic     op_reti,
    input  logic     op_sleep,
    input  logic     irq_ack,
    output src_vec_t flags,
    output src_vec_t mask,
    output logic     irq_req,
    output logic     wake,
    output logic     wake_vec
);
    core_state_t s_d, s_q;
    src_vec_t    pending;

    always_comb begin
        s_d     = s_q;
        pending = s_q.flag & s_q.mask;

        if (flag_wr) s_d.flag = s_q.flag & wr_bits;
        s_d.flag = s_d.flag | ev;

        if (mask_wr) s_d.mask = wr_bits;

        if (op_eni || op_reti)  s_d.gie = 1'b1;
        if (op_disi || irq_ack) s_d.gie = 1'b0;

        irq_req  = s_q.gie & (|pending);
        wake     = s_q.asleep & pending[SRC_PORT];
        wake_vec = s_q.gie;

        if (op_sleep) s_d.asleep = 1'b1;
        if (wake)     s_d.asleep = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags = s_q.flag;
    assign mask  = s_q.mask;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag_chk
        // R2: a flag only rises when its source fired
        a_r2_set_by_event: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(s_q.flag[i]) && s_q.flag[i]) |-> $past(ev[i]));
        // R3: a zero written with no event clears the flag
        a_r3_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_wr && !wr_bits[i] && !ev[i]) |=> !s_q.flag[i]);
    end

    // R5: disable leaves the global enable low
    a_r5_disi_wins: assert property (@(posedge clk) disable iff (!rst_n)
        op_disi |=> !s_q.gie);
    // R7: acknowledge leaves the global enable low
    a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !s_q.gie);
    // R6: a request implies something enabled is pending
    a_r6_req_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((flags & mask) != '0));
    // R10: wake is a single pulse and leaves sleep
    a_r10_wake_once: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (!wake && !s_q.asleep));
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
    import irq_wake_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              flag_wr_en,
    input  logic              mask_wr_en,
    output logic [REG_W-1:0]  flag_rd_data,
    output logic [REG_W-1:0]  mask_rd_data,
    input  logic              tmr_ovf,
    input  logic [PORT_W-1:0] port_in,
    input  logic              port_rd,
    input  logic              ext_pin,
    input  logic              ext_sel,
    input  logic              op_eni,
    input  logic              op_disi,
    input  logic              op_reti,
    input  logic              op_sleep,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic              wake,
    output logic              wake_vec
);
    localparam int PAD_W = REG_W - NUM_SRC;

    logic     port_change;
    logic     ext_fall;
    src_vec_t ev;
    src_vec_t flags;
    src_vec_t mask;

    iwc_port_change #(.PORT_W(PORT_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_in (port_in),
        .port_rd (port_rd),
        .change  (port_change)
    );

    iwc_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .sel   (ext_sel),
        .fall  (ext_fall)
    );

    always_comb begin
        ev           = '0;
        ev[SRC_TMR]  = tmr_ovf;
        ev[SRC_PORT] = port_change;
        ev[SRC_EXT]  = ext_fall;
    end

    iwc_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .flag_wr  (flag_wr_en),
        .mask_wr  (mask_wr_en),
        .wr_bits  (wr_data[NUM_SRC-1:0]),
        .op_eni   (op_eni),
        .op_disi  (op_disi),
        .op_reti  (op_reti),
        .op_sleep (op_sleep),
        .irq_ack  (irq_ack),
        .flags    (flags),
        .mask     (mask),
        .irq_req  (irq_req),
        .wake     (wake),
        .wake_vec (wake_vec)
    );

    assign flag_rd_data = {{PAD_W{1'b0}}, flags & mask};
    assign mask_rd_data = {{PAD_W{1'b0}}, mask};

    // R8: the external flag never rises from an unselected pin
    a_r8_ext_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[SRC_EXT]) |-> $past(ext_sel));
    // R4: mask write lands on the next edge
    a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en |=> (mask == $past(wr_data[NUM_SRC-1:0])));
endmodule

// File: tb/irq_wake_ctrl_tb.sv
module irq_wake_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flag_wr_en = 1'b0, mask_wr_en = 1'b0;
    logic [7:0] flag_rd_data, mask_rd_data;
    logic       tmr_ovf = 1'b0;
    logic [7:0] port_in = '0;
    logic       port_rd = 1'b0;
    logic       ext_pin = 1'b1, ext_sel = 1'b0;
    logic       op_eni = 1'b0, op_disi = 1'b0, op_reti = 1'b0, op_sleep = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_req, wake, wake_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_wake_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .flag_wr_en(flag_wr_en),
        .mask_wr_en(mask_wr_en), .flag_rd_data(flag_rd_data), .mask_rd_data(mask_rd_data),
        .tmr_ovf(tmr_ovf), .port_in(port_in), .port_rd(port_rd), .ext_pin(ext_pin),
        .ext_sel(ext_sel), .op_eni(op_eni), .op_disi(op_disi), .op_reti(op_reti),
        .op_sleep(op_sleep), .irq_ack(irq_ack), .irq_req(irq_req), .wake(wake),
        .wake_vec(wake_vec)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_flag(input logic [7:0] d);
        flag_wr_en = 1'b1; wr_data = d; tick(); flag_wr_en = 1'b0;
    endtask

    task automatic wr_mask(input logic [7:0] d);
        mask_wr_en = 1'b1; wr_data = d; tick(); mask_wr_en = 1'b0;
    endtask

    task automatic pulse_tmr();
        tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
    endtask

    task automatic port_read();
        port_rd = 1'b1; tick(); port_rd = 1'b0;
    endtask

    task automatic port_blip();
        port_in = port_in ^ 8'h01; tick(); port_in = port_in ^ 8'h01;
    endtask

    task automatic ext_fall();
        ext_pin = 1'b0; tick(); tick(); tick();
        ext_pin = 1'b1; tick(); tick(); tick();
    endtask

    task automatic strobe_gie(input logic e, input logic d, input logic r, input logic a);
        op_eni = e; op_disi = d; op_reti = r; irq_ack = a;
        tick();
        op_eni = 1'b0; op_disi = 1'b0; op_reti = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        tick(); tick();
        chk("R1 flag_rd in reset", flag_rd_data, 8'h00);
        rst_n = 1'b1;
        tick();
        chk("R1 flag_rd", flag_rd_data, 8'h00);
        chk("R1 mask_rd", mask_rd_data, 8'h00);
        chk("R1 irq_req", {7'd0, irq_req}, 8'h00);
        chk("R1 wake", {7'd0, wake}, 8'h00);

        // R9: reference resets to 0, port stays 0 so no flag yet
        wr_mask(8'hFF);
        chk("R4 mask upper bits zero", mask_rd_data, 8'h07);
        chk("R9 no mismatch at reset ref", flag_rd_data, 8'h00);

        // R2: writing ones cannot set flags
        wr_flag(8'hFF);
        chk("R2 software cannot set", flag_rd_data, 8'h00);

        pulse_tmr();
        chk("R2 timer sets bit0", flag_rd_data, 8'h01);

        // R3 collision: event and clearing write together
        wr_flag(8'h00);
        tmr_ovf = 1'b1; flag_wr_en = 1'b1; wr_data = 8'h00;
        tick();
        tmr_ovf = 1'b0; flag_wr_en = 1'b0;
        chk("R3 event beats clear", flag_rd_data, 8'h01);
        wr_flag(8'h00);
        chk("R3 clear by zero", flag_rd_data, 8'h00);

        // Sweep: every mask against every clear pattern (R3, R4)
        ext_sel = 1'b1;
        port_in = 8'h3C;
        port_read();
        for (int m = 0; m < 8; m++) begin
            for (int c = 0; c < 8; c++) begin
                pulse_tmr();
                port_blip();
                ext_fall();
                wr_mask(8'hF8 | 8'(m));
                chk("R4 mask readback", mask_rd_data, 8'(m));
                chk("R4 flags AND mask", flag_rd_data, 8'(m));
                wr_flag(8'hF8 | 8'(c));
                wr_mask(8'h07);
                chk("R3 clear pattern kept", flag_rd_data, 8'(c));
                wr_flag(8'h00);
            end
        end

        // R8: exact latency and gating
        wr_flag(8'h00);
        ext_sel = 1'b0;
        ext_fall();
        chk("R8 unselected edge ignored", flag_rd_data, 8'h00);
        ext_sel = 1'b1;
        ext_pin = 1'b0;
        tick(); tick();
        chk("R8 not yet after two edges", flag_rd_data, 8'h00);
        tick();
        chk("R8 set on third edge", flag_rd_data, 8'h04);
        ext_pin = 1'b1;
        tick(); tick(); tick();
        wr_flag(8'h00);
        chk("R8 rising edge sets nothing", flag_rd_data, 8'h00);

        // R9: persisting mismatch re-sets the flag
        port_in = 8'h5A;
        port_read();
        wr_flag(8'h00);
        chk("R9 equal port no flag", flag_rd_data, 8'h00);
        port_in = 8'h5B;
        tick();
        chk("R9 change sets bit1", flag_rd_data, 8'h02);
        wr_flag(8'h00);
        chk("R9 persisting mismatch beats clear", flag_rd_data, 8'h02);
        port_read();
        wr_flag(8'h00);
        chk("R9 clear holds after reread", flag_rd_data, 8'h00);

        // R5, R6, R7: global enable
        pulse_tmr();
        wr_mask(8'h01);
        chk("R6 no request without gie", {7'd0, irq_req}, 8'h00);
        strobe_gie(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 eni sets gie", {7'd0, irq_req}, 8'h01);
        strobe_gie(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7 ack drops gie", {7'd0, irq_req}, 8'h00);
        strobe_gie(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 reti sets gie", {7'd0, irq_req}, 8'h01);
        strobe_gie(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R5 disi clears gie", {7'd0, irq_req}, 8'h00);
        strobe_gie(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R5 disi wins over eni", {7'd0, irq_req}, 8'h00);
        strobe_gie(1'b1, 1'b0, 1'b0, 1'b0);
        strobe_gie(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R7 ack wins over eni", {7'd0, irq_req}, 8'h00);
        strobe_gie(1'b1, 1'b0, 1'b0, 1'b0);
        wr_mask(8'h02);
        chk("R6 masked flag no request", {7'd0, irq_req}, 8'h00);
        wr_mask(8'h01);
        chk("R6 request returns", {7'd0, irq_req}, 8'h01);
        wr_flag(8'h00);
        chk("R6 request gone with flag", {7'd0, irq_req}, 8'h00);

        // R10: wake with gie set (vector) then clear (resume)
        wr_mask(8'h07);
        port_in = 8'h11;
        port_read();
        wr_flag(8'h00);
        op_sleep = 1'b1; tick(); op_sleep = 1'b0;
        chk("R10 asleep no wake", {7'd0, wake}, 8'h00);
        pulse_tmr();
        chk("R10 timer does not wake", {7'd0, wake}, 8'h00);
        wr_flag(8'h00);
        port_in = 8'h12;
        tick();
        chk("R10 port change wakes", {7'd0, wake}, 8'h01);
        chk("R10 vector when gie set", {7'd0, wake_vec}, 8'h01);
        tick();
        chk("R10 wake single cycle", {7'd0, wake}, 8'h00);
        chk("R10 awake flag no wake", {7'd0, wake}, 8'h00);
        port_read();
        wr_flag(8'h00);
        strobe_gie(1'b0, 1'b1, 1'b0, 1'b0);
        op_sleep = 1'b1; tick(); op_sleep = 1'b0;
        port_in = 8'h13;
        tick();
        chk("R10 wake with gie clear", {7'd0, wake}, 8'h01);
        chk("R10 resume when gie clear", {7'd0, wake_vec}, 8'h00);
        tick();
        chk("R10 second wake single", {7'd0, wake}, 8'h00);

        done = 1'b1;
        summary();
    end
endmodule